// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block models a single-port synchronous cache memory. Each word is split into byte lanes of nine bits; the default is two lanes, giving 18-bit words. Address, chip selects, strobes, advance, write enables and write data are all taken on the rising clock edge. Read data leaves the array with no output register, so it appears in the same cycle that follows the edge that presented the address.

A burst starts when one of two address strobes is asserted: a processor strobe or a controller strobe. The strobe latches a base address and the chip-select state. A 2-bit beat counter then supplies the low address bits for up to four beats. It steps whenever the advance input is low and no strobe is present. A static order pin picks the sequence. With the pin high, the order is interleaved: the low bits are the start value XOR the beat. With the pin low, the order is linear: the low bits are the start value plus the beat, wrapping modulo 4.

The shared data bus is split into three signals: `din`, `dout`, and an output-drive flag. An asynchronous active-low reset clears only the control state; it has no effect on the array contents. The array depth is `2**ADDR_W` words.

Top module: `fts_burst_ram`

## Requirements
- R1: On an edge where neither strobe takes effect and the advance input is high, the burst address holds and `dout` keeps showing the same word.
- R2: A strobe edge loads `addr` as the base address. It clears the beat counter, so the first beat reads or writes exactly `addr`.
- R3: An edge with no effective strobe and `adv_n` low moves the burst one beat on. The upper address bits (all except bits [1:0]) stay unchanged.
- R4: With `mode` high, beat k of a burst uses low address bits `start[1:0] ^ k`.
- R5: With `mode` low, beat k of a burst uses low address bits `(start[1:0] + k) mod 4`.
- R6: A strobe edge selects the device only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A deselected burst writes nothing and keeps `dq_oe` at 0.
- R7: `oe_n` high forces `dq_oe` to 0 at once, with no clock edge needed. `oe_n` low restores drive on a selected read cycle.
- R8: On a selected read cycle, `dout` equals the stored word at the current burst address right after the edge, with no extra cycle of latency.
- R9: `gw_n` low writes both lanes. Otherwise, with `bwe_n` low, each lane i whose `bw_n[i]` is 0 is written. Lane i is bits [9i+8:9i]. With `bwe_n` high and `gw_n` high, the cycle is a read whatever `bw_n` holds.
- R10: A burst started by the processor strobe is a read on its first edge, even with write enables asserted. The processor strobe has no effect while `ce1_n` is high. When both strobes are low, the controller strobe wins and its write enables apply.
- R11: `dq_oe` is 0 during every write cycle.
- R12: During reset and after its release, until the first selected strobe, the block is deselected and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | ADDR_W | Word address, taken on a strobe edge |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| gw_n | input | 1 | Global write for all lanes, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Flow-through read data |
| dq_oe | output | 1 | High when the data bus would be driven |

## Verification
Several rules are checked by the assertions on every cycle:
- the address holds when the bus is idle;
- the counter clears on a strobe and steps by one on an advance;
- the two burst orders step correctly;
- output drive is off after a deselecting strobe and after a controller-started write;
- a processor-started cycle is a read;
- `oe_n` gates drive combinationally.

Other behaviour can only be shown by the bench scenarios against its own memory model. That covers whether the right word and the right lanes actually reach the array, and whether reads return them with no added latency. The bench sweeps every start address in both burst orders and checks each beat. It also checks that deselected cycles and processor-started first cycles leave the stored contents untouched.

// File: rtl/fts_pkg.sv
package fts_pkg;

  localparam int BEAT_W = 2;

  typedef logic [BEAT_W-1:0] beat_t;

  // low address bits for a given beat of a burst
  function automatic beat_t burst_low(input beat_t start, input beat_t beat,
                                      input logic interleave);
    burst_low = interleave ? (start ^ beat) : beat_t'(start + beat);
  endfunction

endpackage

// File: rtl/fts_burst_ctrl.sv
module fts_burst_ctrl
  import fts_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              mode,
  input  logic [LANES-1:0]  wr_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LANES-1:0]  wr_en,
  output logic              sel,
  output logic              wr_cyc
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q, base_d;
  beat_t             cnt_q, cnt_d;
  logic              sel_q, sel_d;
  logic [LANES-1:0]  wr_q, wr_d;
  logic              proc_go, load, ce_ok;

  // next-state
  always_comb begin
    proc_go = ~adsp_n & ~ce1_n;
    load    = ~adsc_n | proc_go;
    ce_ok   = ~ce1_n & ce2 & ~ce3_n;
    base_d  = base_q;
    cnt_d   = cnt_q;
    sel_d   = sel_q;
    wr_d    = sel_q ? wr_req : '0;
    if (load) begin
      base_d = addr;
      cnt_d  = '0;
      sel_d  = ce_ok;
      // processor-started first beat is always a read
      wr_d   = (~adsc_n & ce_ok) ? wr_req : '0;
    end else if (~adv_n) begin
      cnt_d  = beat_t'(cnt_q + beat_t'(1));
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      wr_q   <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
      wr_q   <= wr_d;
    end
  end

  assign rd_addr = {base_q[ADDR_W-1:BEAT_W], burst_low(base_q[BEAT_W-1:0], cnt_q, mode)};
  assign wr_addr = {base_d[ADDR_W-1:BEAT_W], burst_low(base_d[BEAT_W-1:0], cnt_d, mode)};
  assign wr_en   = rst_n ? wr_d : '0;
  assign sel     = sel_q;
  assign wr_cyc  = |wr_q;

  // R1: idle edge keeps the address
  p_hold_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (adsc_n && !(!adsp_n && !ce1_n) && adv_n) |=> $stable(base_q) && $stable(cnt_q));

  // R2: strobe loads the base and clears the beat
  p_load_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == '0) && (base_q == $past(addr)));

  // R3: advance steps one beat, upper bits untouched
  p_adv_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n) |=> (cnt_q == $past(cnt_q) + 2'd1)
      && (rd_addr[ADDR_W-1:BEAT_W] == $past(rd_addr[ADDR_W-1:BEAT_W])));

  // R4: interleaved order, change in low bits mirrors change in beat
  p_ilv_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !load && !adv_n) |=> !mode
      || ((rd_addr[1:0] ^ $past(rd_addr[1:0])) == (cnt_q ^ $past(cnt_q))));

  // R5: linear order, low bits step by one modulo four
  p_lin_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !load && !adv_n) |=> mode
      || (rd_addr[1:0] == $past(rd_addr[1:0]) + 2'd1));

  // HI_W is used to keep the split explicit
  initial if (HI_W < 1) $error("ADDR_W must exceed the beat width");

endmodule

// File: rtl/fts_lane_array.sv
module fts_lane_array #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_en,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en[g]) mem_q[wr_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    // flow-through: no output register
    assign rdata[g*LANE_W +: LANE_W] = mem_q[rd_addr];
  end

endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              mode,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dq_oe
);

  logic              rst_m_q, rst_s_q;
  logic [LANES-1:0]  wr_req;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [LANES-1:0]  wr_en;
  logic              sel, wr_cyc;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  always_comb begin
    if (!gw_n)       wr_req = '1;
    else if (!bwe_n) wr_req = ~bw_n;
    else             wr_req = '0;
  end

  fts_burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .addr    (addr),
    .adsp_n  (adsp_n),
    .adsc_n  (adsc_n),
    .adv_n   (adv_n),
    .ce1_n   (ce1_n),
    .ce2     (ce2),
    .ce3_n   (ce3_n),
    .mode    (mode),
    .wr_req  (wr_req),
    .rd_addr (rd_addr),
    .wr_addr (wr_addr),
    .wr_en   (wr_en),
    .sel     (sel),
    .wr_cyc  (wr_cyc)
  );

  fts_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) array_i (
    .clk     (clk),
    .wr_addr (wr_addr),
    .wr_en   (wr_en),
    .wdata   (din),
    .rd_addr (rd_addr),
    .rdata   (dout)
  );

  assign dq_oe = sel & ~wr_cyc & ~oe_n;

  // R7: output enable gates drive without a clock
  always_comb begin
    p_oe_async_r7: assert (!(dq_oe && oe_n));
  end

  // R6: a strobe with a failing chip-enable decode leaves drive off
  p_desel_quiet_r6: assert property (@(posedge clk) disable iff (!rst_s_q)
    (!adsc_n && !(!ce1_n && ce2 && !ce3_n)) |=> !dq_oe);

  // R10: a processor-only start is a read
  p_proc_read_r10: assert property (@(posedge clk) disable iff (!rst_s_q)
    (adsc_n && !adsp_n && !ce1_n && ce2 && !ce3_n) |=> (dq_oe == !oe_n));

  // R11: a controller-started global write never drives
  p_write_quiet_r11: assert property (@(posedge clk) disable iff (!rst_s_q)
    (!adsc_n && !ce1_n && ce2 && !ce3_n && !gw_n) |=> !dq_oe);

  // R12: control state comes out of reset deselected
  p_reset_desel_r12: assert property (@(posedge clk)
    !rst_s_q |=> (!dq_oe || !rst_s_q || !adsc_n || !adsp_n || $past(!adsc_n || !adsp_n)));

endmodule

// File: tb/fts_burst_ram_tb_top.sv
module fts_burst_ram_tb_top;

  localparam int AW = 8;
  localparam int DW = 18;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, mode;
  logic          gw_n, bwe_n, oe_n;
  logic [1:0]    bw_n;
  logic [DW-1:0] din, dout;
  logic          dq_oe;

  logic [DW-1:0] model [NW];
  int            vectors = 0;
  int            miscompares = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  fts_burst_ram #(.ADDR_W(AW), .LANE_W(9), .LANES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .mode(mode),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .din(din),
    .dout(dout), .dq_oe(dq_oe)
  );

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    pat = DW'((a * 613 + salt * 97 + 341) & ((1 << DW) - 1));
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 2'b11;
    ce1_n = 0; ce2 = 1; ce3_n = 0; oe_n = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // controller-started global write of one word
  task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; adsc_n = 0; gw_n = 0; din = d;
    tick();
    model[a] = d;
    check(dq_oe == 1'b0, "R11", {17'd0, dq_oe}, '0);
    idle();
  endtask

  // four-beat read burst checked beat by beat
  task automatic rd_burst(input logic [AW-1:0] s, input logic m, input string req);
    logic [AW-1:0] ea;
    mode = m; addr = s; adsc_n = 0;
    tick();
    idle();
    for (int k = 0; k < 4; k++) begin
      if (k > 0) begin
        adv_n = 0;
        tick();
        adv_n = 1;
      end
      ea = {s[AW-1:2], m ? (s[1:0] ^ 2'(k)) : 2'(s[1:0] + 2'(k))};
      check(dout == model[ea], k == 0 ? "R2 R8" : (m ? "R4" : "R5"), dout, model[ea]);
      check(dq_oe == 1'b1, "R8", {17'd0, dq_oe}, 18'd1);
      if (k == 2 && s[3:0] == 4'd0) begin
        oe_n = 1; #1;
        check(dq_oe == 1'b0, "R7", {17'd0, dq_oe}, '0);
        oe_n = 0; #1;
        check(dq_oe == 1'b1, "R7", {17'd0, dq_oe}, 18'd1);
      end
    end
    tick();
    check(dout == model[ea], "R1", dout, model[ea]);
    check(dout == model[ea], req, dout, model[ea]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    idle(); mode = 0; addr = '0; din = '0;
    rst_n = 0;
    repeat (3) tick();
    check(dq_oe == 1'b0, "R12", {17'd0, dq_oe}, '0);
    rst_n = 1;
    repeat (4) tick();
    check(dq_oe == 1'b0, "R12", {17'd0, dq_oe}, '0);

    // fill every word
    for (int a = 0; a < NW; a++) wr_word(AW'(a), pat(a, 0));

    // exhaustive burst sweep, both orders
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < NW; a++) rd_burst(AW'(a), m[0], m[0] ? "R4" : "R5");

    // R9: lane writes inside a linear burst
    mode = 0; addr = 8'h40; adsc_n = 0; bwe_n = 0; bw_n = 2'b10; din = 18'h2A5A5;
    tick();
    model[8'h40][8:0] = din[8:0];
    check(dq_oe == 1'b0, "R11", {17'd0, dq_oe}, '0);
    idle(); adv_n = 0; bwe_n = 0; bw_n = 2'b01; din = 18'h1C3C3;
    tick();
    model[8'h41][17:9] = din[17:9];
    idle(); adv_n = 0; bw_n = 2'b00; din = 18'h3FFFF;
    tick();
    check(dout == model[8'h42], "R9", dout, model[8'h42]);
    idle(); adv_n = 0; gw_n = 0; din = 18'h0F0F0;
    tick();
    model[8'h43] = din;
    idle();
    rd_burst(8'h40, 1'b0, "R9");

    // R10: processor strobe start is a read even with writes asserted
    addr = 8'h80; adsp_n = 0; gw_n = 0; din = 18'h12345;
    tick();
    check(dq_oe == 1'b1, "R10", {17'd0, dq_oe}, 18'd1);
    check(dout == model[8'h80], "R10", dout, model[8'h80]);
    idle();
    rd_burst(8'h80, 1'b1, "R10");

    // R10: processor strobe ignored with ce1_n high
    mode = 0; addr = 8'h90; adsc_n = 0;
    tick();
    idle(); addr = 8'hA0; adsp_n = 0; ce1_n = 1;
    tick();
    check(dout == model[8'h90], "R10", dout, model[8'h90]);
    check(dq_oe == 1'b1, "R10", {17'd0, dq_oe}, 18'd1);
    idle();

    // R10: both strobes, controller wins and writes
    d = 18'h2BEEF;
    addr = 8'hB0; adsc_n = 0; adsp_n = 0; gw_n = 0; din = d;
    tick();
    model[8'hB0] = d;
    check(dq_oe == 1'b0, "R10", {17'd0, dq_oe}, '0);
    idle();
    rd_burst(8'hB0, 1'b0, "R10");

    // R6: three failing decodes, each with a write attempt
    for (int v = 0; v < 3; v++) begin
      addr = 8'hC0; adsc_n = 0; gw_n = 0; din = 18'h33333;
      if (v == 0) ce2 = 0;
      if (v == 1) ce3_n = 1;
      if (v == 2) ce1_n = 1;
      tick();
      check(dq_oe == 1'b0, "R6", {17'd0, dq_oe}, '0);
      idle(); adv_n = 0; gw_n = 0; din = 18'h11111;
      tick();
      check(dq_oe == 1'b0, "R6", {17'd0, dq_oe}, '0);
      idle();
      rd_burst(8'hC0, 1'b0, "R6");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule